// File: doc/BRIEF.md
# Interleaved ADC Sample Demultiplexer

This block takes 8-bit conversion results from two sampling channels, I and Q, and places them onto four output buses after a fixed pipeline latency. Each channel owns a primary bus and a delayed partner bus: `di_o`/`did_o` belong to I and `dq_o`/`dqd_o` belong to Q. Every clock period the block accepts a falling-edge sample and a rising-edge sample for each channel. The rising-edge sample is taken half a period before the falling-edge sample of the same period.

The block has two sampling modes. In independent mode each channel drives its own buses from its falling-edge samples. In interleaved mode one source channel is sampled on both clock edges. Its falling-edge samples go to the I buses and its rising-edge samples go to the Q buses, so the Q buses carry data half a period older. The output can be 1:2 demultiplexed, where each bus pair holds two consecutive samples and refreshes every second cycle. It can also be non-demultiplexed, where only the primary buses run and the delayed partner buses are disabled.

A change of mode flushes the pipeline. The valid flag then stays low until fourteen samples taken under the new mode have entered the pipeline.

Top module: `iq_sample_demux`

## Requirements
- R1: In independent 1:2 mode (`interleave_i`=0, `demux_i`=1), on a valid cycle after clock edge k, `di_o`/`did_o` hold the I falling-edge samples accepted at edges k-13 and k-14, and `dq_o`/`dqd_o` hold the Q falling-edge samples from the same two edges.
- R2: In independent non-demux mode (`interleave_i`=0, `demux_i`=0), on a valid cycle after edge k, `di_o` holds the I falling-edge sample from edge k-13 and `dq_o` holds the Q falling-edge sample from edge k-13.
- R3: In interleaved 1:2 mode (`interleave_i`=1, `demux_i`=1), on a valid cycle after edge k, `di_o`/`did_o` hold the source's falling-edge samples from edges k-13 and k-14. `dq_o`/`dqd_o` hold the source's rising-edge samples from the same edges, which are 13.5 and 14.5 periods old.
- R4: When `demux_i`=0, the enables `oe_o[1]` and `oe_o[3]` are low, and `did_o` and `dqd_o` read zero.
- R5: In interleaved non-demux mode, on a valid cycle after edge k, `di_o` holds the source's falling-edge sample from edge k-13 and `dq_o` holds its rising-edge sample from edge k-13.
- R6: The interleaved source is I when `ext_ctrl_i`=0, whatever `q_sel_i` is. When `ext_ctrl_i`=1, `q_sel_i`=1 selects Q and `q_sel_i`=0 selects I.
- R7: In 1:2 mode, `valid_o` is high only on every second cycle, so two consecutive cycles are never both valid.
- R8: `oe_o` bit order is {DQd, DQ, DId, DI}. It reads 4'b1111 in 1:2 mode and 4'b0101 in non-demux mode, following the mode applied at the latest edge.
- R9: If any mode input differs at edge j from its value at edge j-1, then `valid_o` is low after edges j through j+13. The first valid cycle follows edge j+14, and in 1:2 mode valid cycles then fall at j+14+2n.
- R10: During reset, `valid_o` is low, all data buses read zero and `oe_o` reads 4'b0101. The first edge after reset release behaves like a mode change for R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| interleave_i | input | 1 | 1 = interleaved dual-edge mode, 0 = independent |
| demux_i | input | 1 | 1 = 1:2 demultiplexed output, 0 = non-demux |
| ext_ctrl_i | input | 1 | Enables source selection through `q_sel_i` |
| q_sel_i | input | 1 | Interleaved source select, 1 = Q (needs `ext_ctrl_i`) |
| i_fall_i | input | 8 | I sample, falling edge |
| i_rise_i | input | 8 | I sample, rising edge (half period earlier) |
| q_fall_i | input | 8 | Q sample, falling edge |
| q_rise_i | input | 8 | Q sample, rising edge (half period earlier) |
| di_o | output | 8 | I primary bus |
| did_o | output | 8 | I delayed bus |
| dq_o | output | 8 | Q primary bus |
| dqd_o | output | 8 | Q delayed bus |
| oe_o | output | 4 | Per-bus enable {DQd, DQ, DId, DI} |
| valid_o | output | 1 | Output buses carry fresh data this cycle |

## Verification
Samples are accepted at edge k. Primary buses show them after edge k+13 and delayed buses after edge k+14. Valid reappears exactly fourteen edges after a mode change and, in 1:2 mode, on every second edge after that. The bench drives inputs on the falling clock edge and records each edge's inputs by edge index. It samples outputs on the next falling edge and compares them against history entries thirteen and fourteen edges back, routed under that edge's mode. The valid flag and enables are checked on every cycle, and data only where the model predicts valid.

// File: rtl/iq_demux_pkg.sv
package iq_demux_pkg;
  typedef struct packed {
    logic interleave;
    logic demux;
    logic ext_ctrl;
    logic q_sel;
  } mode_t;
endpackage

// File: rtl/iq_demux_route.sv
module iq_demux_route
  import iq_demux_pkg::*;
#(
  parameter int W = 8
) (
  input  mode_t        mode_i,
  input  logic [W-1:0] i_fall_i,
  input  logic [W-1:0] i_rise_i,
  input  logic [W-1:0] q_fall_i,
  input  logic [W-1:0] q_rise_i,
  output logic [W-1:0] lane_a_o,
  output logic [W-1:0] lane_b_o
);
  logic src_q;
  assign src_q = mode_i.ext_ctrl & mode_i.q_sel;

  always_comb begin
    if (mode_i.interleave) begin
      lane_a_o = src_q ? q_fall_i : i_fall_i;
      lane_b_o = src_q ? q_rise_i : i_rise_i;
    end else begin
      lane_a_o = i_fall_i;
      lane_b_o = q_fall_i;
    end
  end
endmodule

// File: rtl/iq_demux_delay.sv
module iq_demux_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 14
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [W-1:0]             d_i,
  output logic [DEPTH-1:0][W-1:0]  taps_o
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) taps_o[s] <= '0;
      else if (s == 0) taps_o[s] <= d_i;
      else taps_o[s] <= taps_o[(s == 0) ? 0 : s-1];
    end
  end
endmodule

// File: rtl/iq_demux_ctrl.sv
module iq_demux_ctrl
  import iq_demux_pkg::*;
#(
  parameter int FILL = 14
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_t mode_i,
  output mode_t mode_q_o,
  output logic  update_o,
  output logic  valid_d_o
);
  localparam int CW = $clog2(FILL + 1);
  localparam logic [CW-1:0] FULL = CW'(FILL);

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic          change;

  assign change = (mode_i != mode_q_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q_o <= '0;
      phase_q  <= 1'b1;  // first edge then matches a mode change
      cnt_q    <= '0;
    end else begin
      mode_q_o <= mode_i;
      phase_q  <= change ? 1'b0 : ~phase_q;
      if (change)             cnt_q <= CW'(1);
      else if (cnt_q != FULL) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign update_o  = !mode_q_o.demux || phase_q;
  assign valid_d_o = !change && (cnt_q == FULL) && update_o;
endmodule

// File: rtl/iq_sample_demux.sv
module iq_sample_demux
  import iq_demux_pkg::*;
#(
  parameter int W   = 8,
  parameter int LAT = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         interleave_i,
  input  logic         demux_i,
  input  logic         ext_ctrl_i,
  input  logic         q_sel_i,
  input  logic [W-1:0] i_fall_i,
  input  logic [W-1:0] i_rise_i,
  input  logic [W-1:0] q_fall_i,
  input  logic [W-1:0] q_rise_i,
  output logic [W-1:0] di_o,
  output logic [W-1:0] did_o,
  output logic [W-1:0] dq_o,
  output logic [W-1:0] dqd_o,
  output logic [3:0]   oe_o,
  output logic         valid_o
);
  localparam int DEPTH = LAT + 1;

  mode_t mode_in, mode_q;
  logic [W-1:0] lane_a, lane_b;
  logic [DEPTH-1:0][W-1:0] taps_a, taps_b;
  logic update, valid_d;
  logic [W-1:0] di_q, did_q, dq_q, dqd_q;

  assign mode_in = '{interleave: interleave_i, demux: demux_i,
                     ext_ctrl: ext_ctrl_i, q_sel: q_sel_i};

  iq_demux_route #(.W(W)) u_route (
    .mode_i(mode_in), .i_fall_i(i_fall_i), .i_rise_i(i_rise_i),
    .q_fall_i(q_fall_i), .q_rise_i(q_rise_i),
    .lane_a_o(lane_a), .lane_b_o(lane_b)
  );

  iq_demux_delay #(.W(W), .DEPTH(DEPTH)) u_dly_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lane_a), .taps_o(taps_a)
  );

  // rising-edge lane: same stage count, half-period older by sampling
  iq_demux_delay #(.W(W), .DEPTH(DEPTH)) u_dly_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lane_b), .taps_o(taps_b)
  );

  iq_demux_ctrl #(.FILL(DEPTH)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_in),
    .mode_q_o(mode_q), .update_o(update), .valid_d_o(valid_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      di_q <= '0; did_q <= '0; dq_q <= '0; dqd_q <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_d;
      if (update) begin
        di_q  <= taps_a[LAT-1];
        did_q <= taps_a[LAT];
        dq_q  <= taps_b[LAT-1];
        dqd_q <= taps_b[LAT];
      end
    end
  end

  assign oe_o  = {mode_q.demux, 1'b1, mode_q.demux, 1'b1};
  assign di_o  = di_q;
  assign dq_o  = dq_q;
  assign did_o = oe_o[1] ? did_q : '0;
  assign dqd_o = oe_o[3] ? dqd_q : '0;
endmodule

// File: rtl/iq_sample_demux_chk.sv
module iq_sample_demux_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         interleave_i,
  input logic         demux_i,
  input logic         ext_ctrl_i,
  input logic         q_sel_i,
  input logic [W-1:0] did_o,
  input logic [W-1:0] dqd_o,
  input logic [3:0]   oe_o,
  input logic         valid_o
);
  assert_did_off_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o[1] |-> did_o == '0);

  assert_dqd_off_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o[3] |-> dqd_o == '0);

  assert_flush_on_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({interleave_i, demux_i, ext_ctrl_i, q_sel_i}) |=> !valid_o);

  assert_half_rate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && oe_o[1]) |=> !valid_o);
endmodule

bind iq_sample_demux iq_sample_demux_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .interleave_i(interleave_i),
  .demux_i(demux_i), .ext_ctrl_i(ext_ctrl_i), .q_sel_i(q_sel_i),
  .did_o(did_o), .dqd_o(dqd_o), .oe_o(oe_o), .valid_o(valid_o)
);

// File: tb/iq_sample_demux_test.sv
module iq_sample_demux_test;
  localparam int HN = 4096;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic interleave_i = 0, demux_i = 0, ext_ctrl_i = 0, q_sel_i = 0;
  logic [7:0] i_fall_i = 0, i_rise_i = 0, q_fall_i = 0, q_rise_i = 0;
  logic [7:0] di_o, did_o, dq_o, dqd_o;
  logic [3:0] oe_o;
  logic valid_o;

  int checks = 0, errors = 0;
  int edge_n = 0;
  int rel_edge = 0, chg_edge = 0;
  logic [3:0] hm [HN];
  logic [7:0] hif [HN], hir [HN], hqf [HN], hqr [HN];

  always #2 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  iq_sample_demux uut (
    .clk_i(clk), .rst_ni(rst_ni), .interleave_i(interleave_i),
    .demux_i(demux_i), .ext_ctrl_i(ext_ctrl_i), .q_sel_i(q_sel_i),
    .i_fall_i(i_fall_i), .i_rise_i(i_rise_i), .q_fall_i(q_fall_i),
    .q_rise_i(q_rise_i), .di_o(di_o), .did_o(did_o), .dq_o(dq_o),
    .dqd_o(dqd_o), .oe_o(oe_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s edge %0d actual %0h expected %0h", tag, edge_n, act, exp);
    end
  endtask

  // mode bits {interleave, demux, ext, qsel}
  function automatic logic [7:0] lane_a(input int e);
    logic src = hm[e][1] & hm[e][0];
    if (hm[e][3]) return src ? hqf[e] : hif[e];
    return hif[e];
  endfunction

  function automatic logic [7:0] lane_b(input int e);
    logic src = hm[e][1] & hm[e][0];
    if (hm[e][3]) return src ? hqr[e] : hir[e];
    return hqf[e];
  endfunction

  function automatic string mode_tag(input logic [3:0] m);
    if (!m[3]) return m[2] ? "R1" : "R2";
    if (m[1]) return m[2] ? "R6 R3" : "R6 R5";
    return m[2] ? "R3" : "R5";
  endfunction

  task automatic check_edge();
    int k = edge_n;
    logic [3:0] m = hm[k];
    bit dm = m[2];
    int age = k - chg_edge;
    bit ev = (age >= 14) && (!dm || (age % 2 == 0));
    chk(valid_o == ev, dm ? "R7 R9 valid" : "R9 valid", valid_o, ev);
    chk(oe_o == (dm ? 4'b1111 : 4'b0101), "R8 oe", oe_o, dm ? 4'hf : 4'h5);
    if (!dm) begin
      chk(did_o == 8'h00, "R4 did zero", did_o, 0);
      chk(dqd_o == 8'h00, "R4 dqd zero", dqd_o, 0);
    end
    if (ev && valid_o) begin
      chk(di_o == lane_a(k-13), mode_tag(m), di_o, lane_a(k-13));
      chk(dq_o == lane_b(k-13), mode_tag(m), dq_o, lane_b(k-13));
      if (dm) begin
        chk(did_o == lane_a(k-14), mode_tag(m), did_o, lane_a(k-14));
        chk(dqd_o == lane_b(k-14), mode_tag(m), dqd_o, lane_b(k-14));
      end
    end
  endtask

  task automatic apply(input logic [3:0] m);
    int e = edge_n + 1;
    logic [3:0] pm = {interleave_i, demux_i, ext_ctrl_i, q_sel_i};
    {interleave_i, demux_i, ext_ctrl_i, q_sel_i} = m;
    i_fall_i = 8'($urandom); i_rise_i = 8'($urandom);
    q_fall_i = 8'($urandom); q_rise_i = 8'($urandom);
    hm[e] = m; hif[e] = i_fall_i; hir[e] = i_rise_i;
    hqf[e] = q_fall_i; hqr[e] = q_rise_i;
    if (e == rel_edge || m != pm) chg_edge = e;
  endtask

  task automatic run_seg(input logic [3:0] m, input int len);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      check_edge();
      apply(m);
    end
  endtask

  initial begin
    logic [3:0] dir [10] = '{4'b0000, 4'b0100, 4'b1000, 4'b1100, 4'b1010,
                             4'b1011, 4'b1111, 4'b1101, 4'b1110, 4'b0111};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R10 reset valid", valid_o, 0);
    chk({di_o, did_o, dq_o, dqd_o} == 32'h0, "R10 reset data",
        {di_o, did_o, dq_o, dqd_o}, 0);
    chk(oe_o == 4'b0101, "R10 reset oe", oe_o, 5);
    rel_edge = edge_n + 1;
    rst_ni = 1'b1;
    apply(4'b0100);
    run_seg(4'b0100, 40);
    for (int s = 0; s < 10; s++) run_seg(dir[s], 40);
    run_seg(4'b1100, 9);   // flush before fill completes
    run_seg(4'b1110, 13);
    run_seg(4'b1111, 30);
    for (int s = 0; s < 25; s++) run_seg(4'($urandom), int'($urandom_range(8, 50)));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule